// File: doc/BRIEF.md
# Multiply-High-Word Execution Unit

This unit executes the signed 32×32 multiply-high-word integer instruction for a RISC core with 64-bit registers. The issuing stage pulses `start_i` with the 32-bit instruction word, both 64-bit source operands and the current summary-overflow bit. The unit checks that the word encodes this instruction. It then multiplies the low 32 bits of the operands as signed values over a fixed number of cycles and returns the upper 32 bits of the 64-bit product, zero-extended to 64 bits. It also returns the destination register index.

When the record flag in the instruction is set, the unit also produces the 4-bit condition field 0. That field holds a signed compare of the 32-bit result against zero, plus a copy of the summary-overflow bit. An instruction word that does not decode as this instruction still runs the full latency. It then finishes with an illegal flag and no write enables. The unit does not access the register file, resolve hazards or raise exceptions.

Top module: `mulhw_unit`

## Requirements
- R1: The word is accepted when bits 31:26 (big-endian bits 0–5) equal 31 and bits 9:1 (big-endian bits 22–30) equal 75. The overflow-enable bit (bit 10) does not affect decode or result. The unit has no overflow output.
- R2: `rd_idx_o` equals instruction bits 25:21 (big-endian bits 6–10).
- R3: `rd_data_o[31:0]` equals bits 63:32 of the signed product of `opa_i[31:0]` and `opb_i[31:0]`. Operand bits 63:32 have no effect.
- R4: `rd_data_o[63:32]` is always zero when `rd_we_o` is 1.
- R5: When the record flag (bit 0, big-endian bit 31) is 1, `cr_we_o` pulses with done. `cr_o` = {LT, GT, EQ, SO}, where LT, GT and EQ come from a signed compare of the 32-bit result with zero, and exactly one of them is 1. SO is the `so_i` value captured at start.
- R6: When the record flag is 0, `cr_we_o` stays 0.
- R7: A start accepted at clock edge k raises `busy_o` after edge k. `done_o` is high for exactly one cycle, after edge k+4, and `busy_o` is low in that cycle.
- R8: A `start_i` seen while `busy_o` is 1 is ignored. The running result and its timing are unchanged, and no extra done is produced.
- R9: A non-matching word gives `illegal_o` together with `done_o`, with `rd_we_o` and `cr_we_o` both 0.
- R10: −2^31 × −2^31 gives 0x40000000 (GT). −1 × 1 gives 0xFFFFFFFF (LT). Any value × 0 gives 0 (EQ).
- R11: A start presented in the cycle in which `done_o` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, honoured only when idle |
| insn_i | input | 32 | Instruction word |
| opa_i | input | 64 | Source operand A |
| opb_i | input | 64 | Source operand B |
| so_i | input | 1 | Summary-overflow bit of the fixed-point exception register |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Instruction word did not decode |
| rd_we_o | output | 1 | Destination write enable |
| rd_idx_o | output | 5 | Destination register index |
| rd_data_o | output | 64 | Zero-extended high product word |
| cr_we_o | output | 1 | Condition field 0 write enable |
| cr_o | output | 4 | {LT, GT, EQ, SO} |

## Verification
The completion pulse of one operation can fall in the same cycle as the acceptance of the next start. The bench provokes this by issuing operations back to back: the driver presents the next start as soon as `busy_o` drops, which is exactly the cycle in which `done_o` is high. The scoreboard stamps each queued item with the cycle in which its done is due. It fails any completion that arrives early, late or without a pending item. It also compares result, index and condition bits, so a dropped or corrupted back-to-back start is reported.

// File: rtl/mulhw_pkg.sv
package mulhw_pkg;
  localparam int XLEN = 64;
  localparam int WLEN = 32;
  localparam logic [5:0] PRIM_OP = 6'd31;
  localparam logic [8:0] EXT_OP  = 9'd75;

  // bit 31 of the word is big-endian bit 0
  typedef struct packed {
    logic [5:0] prim;
    logic [4:0] rt;
    logic [4:0] ra;
    logic [4:0] rb;
    logic       oe;
    logic [8:0] xo;
    logic       rc;
  } insn_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crf_t;
endpackage

// File: rtl/mulhw_decode.sv
module mulhw_decode
  import mulhw_pkg::*;
(
  input  logic [31:0] insn_i,
  output logic        match_o,
  output logic [4:0]  rt_o,
  output logic        rc_o
);
  insn_t f;
  logic  unused_fields;

  assign f             = insn_t'(insn_i);
  assign match_o       = (f.prim == PRIM_OP) && (f.xo == EXT_OP);
  assign rt_o          = f.rt;
  assign rc_o          = f.rc;
  // operand selects belong to the register file; oe has no effect
  assign unused_fields = ^{f.ra, f.rb, f.oe};
endmodule

// File: rtl/mulhw_seq_mult.sv
module mulhw_seq_mult #(
  parameter int WLEN    = 32,
  parameter int DIGIT_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [WLEN-1:0]     a_i,
  input  logic [WLEN-1:0]     b_i,
  output logic                busy_o,
  output logic                vld_o,
  output logic [2*WLEN-1:0]   prod_o
);
  localparam int PW    = 2 * WLEN;
  localparam int STEPS = WLEN / DIGIT_W;
  localparam int CNT_W = $clog2(STEPS + 1);

  logic [PW-1:0]    mcand_q, acc_q, pp, sum;
  logic [WLEN-1:0]  mplier_q;
  logic             neg_q, busy_q, vld_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [WLEN-1:0] mag(input logic [WLEN-1:0] v);
    return v[WLEN-1] ? (~v + 1'b1) : v;
  endfunction

  assign pp  = mcand_q * PW'(mplier_q[DIGIT_W-1:0]);
  assign sum = acc_q + pp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      neg_q    <= 1'b0;
      busy_q   <= 1'b0;
      vld_q    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      vld_q <= 1'b0;
      if (load_i && !busy_q) begin
        mcand_q  <= PW'(mag(a_i));
        mplier_q <= mag(b_i);
        acc_q    <= '0;
        neg_q    <= a_i[WLEN-1] ^ b_i[WLEN-1];
        cnt_q    <= CNT_W'(STEPS - 1);
        busy_q   <= 1'b1;
      end else if (busy_q) begin
        mcand_q  <= mcand_q << DIGIT_W;
        mplier_q <= mplier_q >> DIGIT_W;
        if (cnt_q == '0) begin
          acc_q  <= neg_q ? (~sum + 1'b1) : sum;
          busy_q <= 1'b0;
          vld_q  <= 1'b1;
        end else begin
          acc_q  <= sum;
          cnt_q  <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign vld_o  = vld_q;
  assign prod_o = acc_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);
  // R7
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_o) |-> $past(busy_o) && !busy_o);
  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && load_i) |=> (busy_o || vld_o));
  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(load_i));
endmodule

// File: rtl/mulhw_format.sv
module mulhw_format
  import mulhw_pkg::*;
(
  input  logic [XLEN-1:0] prod_i,
  input  logic            so_i,
  output logic [XLEN-1:0] rd_data_o,
  output crf_t            cr_o
);
  logic [WLEN-1:0] hi;
  logic            unused_lo;

  assign hi        = prod_i[XLEN-1:WLEN];
  assign unused_lo = ^prod_i[WLEN-1:0];
  assign rd_data_o = {{(XLEN-WLEN){1'b0}}, hi};

  always_comb begin
    cr_o.lt = hi[WLEN-1];
    cr_o.eq = (hi == '0);
    cr_o.gt = !hi[WLEN-1] && (hi != '0);
    cr_o.so = so_i;
  end
endmodule

// File: rtl/mulhw_unit.sv
module mulhw_unit
  import mulhw_pkg::*;
#(
  parameter int DIGIT_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [31:0] insn_i,
  input  logic [63:0] opa_i,
  input  logic [63:0] opb_i,
  input  logic        so_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        illegal_o,
  output logic        rd_we_o,
  output logic [4:0]  rd_idx_o,
  output logic [63:0] rd_data_o,
  output logic        cr_we_o,
  output logic [3:0]  cr_o
);
  logic        match, rc, accept, vld;
  logic [4:0]  rt;
  logic [4:0]  rt_q;
  logic        rc_q, so_q, ill_q;
  logic [XLEN-1:0] prod;
  crf_t        crf;
  logic        unused_hi;

  assign unused_hi = ^{opa_i[XLEN-1:WLEN], opb_i[XLEN-1:WLEN]};

  mulhw_decode u_dec (
    .insn_i  (insn_i),
    .match_o (match),
    .rt_o    (rt),
    .rc_o    (rc)
  );

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rt_q  <= '0;
      rc_q  <= 1'b0;
      so_q  <= 1'b0;
      ill_q <= 1'b0;
    end else if (accept) begin
      rt_q  <= rt;
      rc_q  <= rc;
      so_q  <= so_i;
      ill_q <= !match;
    end
  end

  mulhw_seq_mult #(.WLEN(WLEN), .DIGIT_W(DIGIT_W)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .a_i    (opa_i[WLEN-1:0]),
    .b_i    (opb_i[WLEN-1:0]),
    .busy_o (busy_o),
    .vld_o  (vld),
    .prod_o (prod)
  );

  mulhw_format u_fmt (
    .prod_i    (prod),
    .so_i      (so_q),
    .rd_data_o (rd_data_o),
    .cr_o      (crf)
  );

  assign done_o    = vld;
  assign illegal_o = vld && ill_q;
  assign rd_we_o   = vld && !ill_q;
  assign cr_we_o   = vld && !ill_q && rc_q;
  assign rd_idx_o  = rt_q;
  assign cr_o      = crf;

  // R4
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> (rd_data_o[63:32] == 32'h0));
  // R5
  cr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> ($countones(cr_o[3:1]) == 1));
  // R9
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (done_o && !rd_we_o && !cr_we_o));
  // R6
  cr_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> (rd_we_o && done_o));
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/mulhw_unit_tb.sv
`timescale 1ns/1ps
module mulhw_unit_tb;
  localparam time TCLK = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] opa = '0, opb = '0;
  logic        so = 1'b0;
  logic        busy, done, illegal, rd_we, cr_we;
  logic [4:0]  rd_idx;
  logic [63:0] rd_data;
  logic [3:0]  cr;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  typedef struct {
    int          due;
    logic        ill;
    logic [4:0]  idx;
    logic [63:0] data;
    logic        crwe;
    logic [3:0]  crv;
    string       req;
  } exp_t;
  exp_t sb[$];

  mulhw_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .insn_i(insn),
    .opa_i(opa), .opb_i(opb), .so_i(so), .busy_o(busy), .done_o(done),
    .illegal_o(illegal), .rd_we_o(rd_we), .rd_idx_o(rd_idx),
    .rd_data_o(rd_data), .cr_we_o(cr_we), .cr_o(cr)
  );

  always #(TCLK/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [31:0] mk(input logic [5:0] prim, input logic [4:0] rt,
                                     input logic oe, input logic [8:0] xo, input logic rc);
    return {prim, rt, 5'd3, 5'd4, oe, xo, rc};
  endfunction

  task automatic issue(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                       input logic s, input string req);
    exp_t e;
    longint p;
    logic [31:0] hi;
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; insn = w; opa = a; opb = b; so = s;
    p  = longint'($signed(a[31:0])) * longint'($signed(b[31:0]));
    hi = p[63:32];
    e.due  = cyc + 5;
    e.ill  = !(w[31:26] == 6'd31 && w[9:1] == 9'd75);
    e.idx  = w[25:21];
    e.data = {32'h0, hi};
    e.crwe = !e.ill && w[0];
    e.crv  = {hi[31], !hi[31] && hi != 0, hi == 0, s};
    e.req  = req;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R8 unexpected done", 64'(done), 64'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.due, {e.req, " R7 latency"}, 64'(cyc), 64'(e.due));
        chk(busy == 1'b0, "R7 busy low at done", 64'(busy), 64'h0);
        chk(illegal == e.ill, {e.req, " R9 illegal"}, 64'(illegal), 64'(e.ill));
        chk(rd_we == !e.ill, {e.req, " R9 rd_we"}, 64'(rd_we), 64'(!e.ill));
        chk(cr_we == e.crwe, {e.req, " R5/R6 cr_we"}, 64'(cr_we), 64'(e.crwe));
        if (!e.ill) begin
          chk(rd_idx == e.idx, {e.req, " R2 rd_idx"}, 64'(rd_idx), 64'(e.idx));
          chk(rd_data == e.data, {e.req, " R3/R4 rd_data"}, rd_data, e.data);
        end
        if (e.crwe)
          chk(cr == e.crv, {e.req, " R5 cr"}, 64'(cr), 64'(e.crv));
      end
    end
  end

  initial begin
    #(TCLK * 150000);
    chk(1'b0, "watchdog", 64'(cyc), 64'h0);
    finish_run();
  end

  initial begin
    logic [31:0] ok_rc, ok_norc;
    ok_rc   = mk(6'd31, 5'd7, 1'b0, 9'd75, 1'b1);
    ok_norc = mk(6'd31, 5'd12, 1'b0, 9'd75, 1'b0);
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && rd_we == 0 && cr_we == 0, "reset outputs",
        64'({busy, done, rd_we, cr_we}), 64'h0);
    rst_n = 1'b1;

    // R10 corners
    issue(ok_rc, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 1'b0, "R10 min*min");
    issue(ok_rc, 64'h0000_0000_FFFF_FFFF, 64'h1, 1'b0, "R10 -1*1");
    issue(ok_rc, 64'h0000_0000_1234_5678, 64'h0, 1'b1, "R10 x*0");
    // R3 upper operand bits ignored
    issue(ok_rc, 64'hDEAD_BEEF_7FFF_FFFF, 64'hCAFE_F00D_7FFF_FFFF, 1'b0, "R3 max*max junk hi");
    issue(ok_norc, 64'hFFFF_FFFF_8000_0000, 64'h0000_0000_7FFF_FFFF, 1'b1, "R6 no record");
    // R1 oe bit set still decodes
    issue(mk(6'd31, 5'd31, 1'b1, 9'd75, 1'b1), 64'h0000_0000_0001_0000, 64'h0000_0000_FFFF_0000, 1'b1, "R1 oe=1");
    // R9 wrong primary / extended opcode
    issue(mk(6'd30, 5'd5, 1'b0, 9'd75, 1'b1), 64'h5, 64'h7, 1'b0, "R9 bad prim");
    issue(mk(6'd31, 5'd5, 1'b0, 9'd11, 1'b1), 64'h5, 64'h7, 1'b0, "R9 bad ext");
    issue(ok_rc, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0005, 1'b1, "R5 small pos");

    // R8 start while busy is ignored
    issue(ok_rc, 64'h0000_0000_4000_0000, 64'h0000_0000_0000_0010, 1'b0, "R8 first");
    start = 1'b1; insn = ok_rc; opa = 64'hFFFF_FFFF; opb = 64'h8000_0000;
    @(negedge clk);
    start = 1'b0;

    // R11 back-to-back plus pseudo-random coverage
    for (int i = 0; i < 40; i++) begin
      logic [63:0] a, b;
      a = {$urandom(), $urandom()};
      b = {$urandom(), $urandom()};
      issue(mk(6'd31, 5'(i), 1'b0, 9'd75, 1'(i)), a, b, 1'(i >> 1), "R11 b2b");
    end

    for (int w = 0; w < 50 && sb.size() != 0; w++) @(negedge clk);
    chk(sb.size() == 0, "R7 all done", 64'(sb.size()), 64'h0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule